// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one node of a two-dimensional mesh that never stores a flit. Each cycle up to four flits arrive on the north, east, south and west links. Every one of them is given an output link, or the ejection port, and leaves through the output register at the next clock edge. The preferred direction comes from X-then-Y dimension-ordered routing. When two flits want the same output, the older flit gets it. A flit that loses is sent out on the lowest-numbered link that is still free, which is a deflection.

A local source may offer one new flit per cycle. The offer is accepted in the same cycle only when some link output is still unused after all arriving flits have been placed. A refused offer is not lost: the source keeps waiting, and the router flags that cycle as starved. The starved flag and a per-cycle deflection count feed an external congestion monitor.

The node's own coordinate is fixed by parameters. A flit is a packed vector, most significant field first: destination X (`XW` bits), destination Y (`YW` bits), age (`AW` bits), payload (`PW` bits). Link index order is N=0, E=1, S=2, W=3. North is the direction of increasing Y and east is the direction of increasing X.

Top module: `defl_router`

## Requirements
- R1: An arriving flit's preferred output is E when its destination X is greater than the node's X and W when it is smaller. When the X values are equal, the preferred output is N when destination Y is greater, S when it is smaller, and the ejection port when both coordinates match. An uncontested flit leaves on its preferred output.
- R2: When several flits prefer the same output, the flit with the larger age field gets it. Between equal ages the lower link index wins, with N first, then E, S and W, and the local injection flit last.
- R3: Every valid arriving flit leaves exactly once, one clock after it arrives. A flit that cannot take its preferred output goes out on the lowest-indexed link output not yet taken by an older or higher-priority flit.
- R4: At most one flit per cycle is ejected, and only a flit whose destination equals the node's coordinate. A second such flit is deflected onto a link under R3.
- R5: A flit leaving on a link carries its arriving age plus one, saturating at the all-ones value. An ejected flit keeps its arriving age unchanged.
- R6: `inj_rdy` is high in the same cycle exactly when fewer than four link outputs are taken by arriving flits. When `inj_vld` and `inj_rdy` are both high, the new flit enters with age 0. It leaves on its preferred link if that link is free, and otherwise on the lowest-indexed free link, with age 1.
- R7: `starved` is high in the cycle after one in which `inj_vld` was high and `inj_rdy` was low, and low otherwise.
- R8: `defl_cnt` shows, one cycle later, how many arriving flits did not receive their preferred output. A local-destined flit that is refused ejection counts as one of them.
- R9: In each cycle, the number of valid link outputs plus the ejection valid equals the number of arriving flits in the previous cycle plus one if an injection was accepted.
- R10: While `rst_n` is low, all link-output valids, `ej_vld`, `starved` and `defl_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_vld | input | NLINK (4) | Valid per arriving link, index N,E,S,W |
| lin_flit | input | NLINK x FW | Arriving flits, packed {dst_x, dst_y, age, payload} |
| inj_vld | input | 1 | Local source offers a flit |
| inj_dx | input | XW | Destination X of offered flit |
| inj_dy | input | YW | Destination Y of offered flit |
| inj_pay | input | PW | Payload of offered flit |
| inj_rdy | output | 1 | Offer accepted this cycle (a link output is free) |
| lout_vld | output | NLINK (4) | Valid per outgoing link, registered |
| lout_flit | output | NLINK x FW | Outgoing flits with updated age, registered |
| ej_vld | output | 1 | Ejected flit valid, registered |
| ej_flit | output | FW | Ejected flit, registered |
| starved | output | 1 | Previous cycle had a refused injection |
| defl_cnt | output | 3 | Deflections made in the previous cycle |

## Verification
The bench builds the router with a 3-bit age field and places the node at (2,1) in a 3-bit coordinate space. The narrow age field makes equal ages common in random traffic, so the link-index tie-break is exercised often, and a single directed flit reaches the saturation value 7. Random destinations range from 0 to 4 on both axes, so every direction, local ejection and contention between two local flits arise with all four links loaded, including full-load cycles that must refuse an injection.

// File: rtl/defl_rtr_pkg.sv
package defl_rtr_pkg;

    localparam int unsigned NLINK = 4;

    // Link indices double as the tie-break order (lower wins).
    typedef enum logic [2:0] {
        PORT_N = 3'd0,
        PORT_E = 3'd1,
        PORT_S = 3'd2,
        PORT_W = 3'd3,
        PORT_L = 3'd4
    } port_e;

endpackage

// File: rtl/defl_dor_route.sv
module defl_dor_route
    import defl_rtr_pkg::*;
#(
    parameter int unsigned XW   = 3,
    parameter int unsigned YW   = 3,
    parameter int unsigned MY_X = 2,
    parameter int unsigned MY_Y = 2
) (
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    output port_e         pref
);

    localparam logic [XW-1:0] HX = XW'(MY_X);
    localparam logic [YW-1:0] HY = YW'(MY_Y);

    // X dimension first, then Y, then local.
    always_comb begin
        if (dst_x > HX)      pref = PORT_E;
        else if (dst_x < HX) pref = PORT_W;
        else if (dst_y > HY) pref = PORT_N;
        else if (dst_y < HY) pref = PORT_S;
        else                 pref = PORT_L;
    end

endmodule

// File: rtl/defl_alloc.sv
module defl_alloc
    import defl_rtr_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NLINK-1:0]            vld,
    input  logic [NLINK-1:0][AW-1:0]    age,
    input  port_e                       pref [NLINK],
    input  logic                        inj_vld,
    input  port_e                       inj_pref,
    output logic [NLINK-1:0]            out_used,
    output logic [NLINK-1:0][2:0]       out_src,
    output logic                        ej_used,
    output logic [1:0]                  ej_src,
    output logic                        inj_fire,
    output logic                        inj_rdy,
    output logic [2:0]                  defl_cnt
);

    logic [2:0] rank [NLINK];
    logic       free_found;

    // Rank = number of valid flits that beat this one (older, or same age on a lower index).
    always_comb begin : rank_calc
        for (int i = 0; i < NLINK; i++) begin
            rank[i] = '0;
            for (int j = 0; j < NLINK; j++) begin
                if (j != i && vld[j] &&
                    (age[j] > age[i] || (age[j] == age[i] && j < i)))
                    rank[i] = rank[i] + 3'd1;
            end
        end
    end

    // Place flits in rank order; losers take the lowest free link.
    always_comb begin : place
        out_used   = '0;
        out_src    = '0;
        ej_used    = 1'b0;
        ej_src     = '0;
        inj_fire   = 1'b0;
        defl_cnt   = '0;
        free_found = 1'b0;
        for (int r = 0; r < NLINK; r++) begin
            for (int i = 0; i < NLINK; i++) begin
                if (vld[i] && rank[i] == 3'(r)) begin
                    if (pref[i] == PORT_L && !ej_used) begin
                        ej_used = 1'b1;
                        ej_src  = 2'(i);
                    end else if (pref[i] != PORT_L && !out_used[pref[i][1:0]]) begin
                        out_used[pref[i][1:0]] = 1'b1;
                        out_src[pref[i][1:0]]  = 3'(i);
                    end else begin
                        defl_cnt   = defl_cnt + 3'd1;
                        free_found = 1'b0;
                        for (int k = 0; k < NLINK; k++) begin
                            if (!free_found && !out_used[k]) begin
                                free_found  = 1'b1;
                                out_used[k] = 1'b1;
                                out_src[k]  = 3'(i);
                            end
                        end
                    end
                end
            end
        end
        inj_rdy = ~&out_used;
        if (inj_vld && inj_rdy) begin
            inj_fire = 1'b1;
            if (inj_pref != PORT_L && !out_used[inj_pref[1:0]]) begin
                out_used[inj_pref[1:0]] = 1'b1;
                out_src[inj_pref[1:0]]  = 3'd4;
            end else begin
                free_found = 1'b0;
                for (int k = 0; k < NLINK; k++) begin
                    if (!free_found && !out_used[k]) begin
                        free_found  = 1'b1;
                        out_used[k] = 1'b1;
                        out_src[k]  = 3'd4;
                    end
                end
            end
        end
    end

    // Checker-side count of how many outputs each input landed on.
    logic [NLINK-1:0][2:0] hit_cnt;
    always_comb begin
        for (int i = 0; i < NLINK; i++) begin
            hit_cnt[i] = (ej_used && ej_src == 2'(i)) ? 3'd1 : 3'd0;
            for (int k = 0; k < NLINK; k++)
                if (out_used[k] && out_src[k] == 3'(i)) hit_cnt[i] = hit_cnt[i] + 3'd1;
        end
    end

    for (genvar g = 0; g < NLINK; g++) begin : g_chk
        p_every_flit_leaves_r3: assert property (@(posedge clk) disable iff (!rst_n)
            hit_cnt[g] == {2'b00, vld[g]});
    end

    p_eject_local_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ej_used |-> (vld[ej_src] && pref[ej_src] == PORT_L));

    p_inject_needs_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_fire |-> !((&vld) && !ej_used));

    p_deflect_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        defl_cnt <= 3'($countones(vld)));

endmodule

// File: rtl/defl_router.sv
module defl_router
    import defl_rtr_pkg::*;
#(
    parameter int unsigned XW   = 3,
    parameter int unsigned YW   = 3,
    parameter int unsigned AW   = 4,
    parameter int unsigned PW   = 8,
    parameter int unsigned MY_X = 2,
    parameter int unsigned MY_Y = 2,
    localparam int unsigned FW  = XW + YW + AW + PW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NLINK-1:0]           lin_vld,
    input  logic [NLINK-1:0][FW-1:0]   lin_flit,
    input  logic                       inj_vld,
    input  logic [XW-1:0]              inj_dx,
    input  logic [YW-1:0]              inj_dy,
    input  logic [PW-1:0]              inj_pay,
    output logic                       inj_rdy,
    output logic [NLINK-1:0]           lout_vld,
    output logic [NLINK-1:0][FW-1:0]   lout_flit,
    output logic                       ej_vld,
    output logic [FW-1:0]              ej_flit,
    output logic                       starved,
    output logic [2:0]                 defl_cnt
);

    localparam int unsigned AGE_LO = PW;
    localparam int unsigned DY_LO  = PW + AW;
    localparam int unsigned DX_LO  = PW + AW + YW;

    port_e                     pref [NLINK];
    port_e                     inj_pref;
    logic [NLINK-1:0][AW-1:0]  in_age;
    logic [NLINK-1:0]          out_used;
    logic [NLINK-1:0][2:0]     out_src;
    logic                      ej_used;
    logic [1:0]                ej_src;
    logic                      inj_fire;
    logic [2:0]                defl_nxt;
    logic [FW-1:0]             inj_flit;
    logic [NLINK-1:0][FW-1:0]  nxt_flit;
    logic [FW-1:0]             base_tmp;
    logic [AW-1:0]             age_tmp;

    for (genvar g = 0; g < NLINK; g++) begin : g_route
        defl_dor_route #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt (
            .dst_x (lin_flit[g][DX_LO +: XW]),
            .dst_y (lin_flit[g][DY_LO +: YW]),
            .pref  (pref[g])
        );
        assign in_age[g] = lin_flit[g][AGE_LO +: AW];
    end

    defl_dor_route #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_rt_inj (
        .dst_x (inj_dx),
        .dst_y (inj_dy),
        .pref  (inj_pref)
    );

    defl_alloc #(.AW(AW)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (lin_vld),
        .age      (in_age),
        .pref     (pref),
        .inj_vld  (inj_vld),
        .inj_pref (inj_pref),
        .out_used (out_used),
        .out_src  (out_src),
        .ej_used  (ej_used),
        .ej_src   (ej_src),
        .inj_fire (inj_fire),
        .inj_rdy  (inj_rdy),
        .defl_cnt (defl_nxt)
    );

    assign inj_flit = {inj_dx, inj_dy, {AW{1'b0}}, inj_pay};

    // Select the source for each link and advance its age (saturating).
    always_comb begin
        base_tmp = '0;
        age_tmp  = '0;
        for (int k = 0; k < NLINK; k++) begin
            base_tmp = out_src[k][2] ? inj_flit : lin_flit[out_src[k][1:0]];
            age_tmp  = base_tmp[AGE_LO +: AW];
            if (age_tmp != {AW{1'b1}}) age_tmp = age_tmp + 1'b1;
            nxt_flit[k] = base_tmp;
            nxt_flit[k][AGE_LO +: AW] = age_tmp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lout_vld  <= '0;
            lout_flit <= '0;
            ej_vld    <= 1'b0;
            ej_flit   <= '0;
            starved   <= 1'b0;
            defl_cnt  <= '0;
        end else begin
            lout_vld  <= out_used;
            lout_flit <= nxt_flit;
            ej_vld    <= ej_used;
            ej_flit   <= lin_flit[ej_src];
            starved   <= inj_vld && !inj_rdy;
            defl_cnt  <= defl_nxt;
        end
    end

    p_flit_conservation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_used) + 32'(ej_used)) == ($countones(lin_vld) + 32'(inj_fire)));

    p_starved_follows_refusal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld && !inj_rdy) |=> starved);

    for (genvar g = 0; g < NLINK; g++) begin : g_age_chk
        p_link_age_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            lout_vld[g] |-> (lout_flit[g][AGE_LO +: AW] != '0));
    end

endmodule

// File: tb/defl_router_test.sv
module defl_router_test;

    localparam int XW = 3, YW = 3, AW = 3, PW = 8;
    localparam int MX = 2, MY = 1;
    localparam int FW = XW + YW + AW + PW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        lin_vld = '0;
    logic [3:0][FW-1:0] lin_flit = '0;
    logic              inj_vld = 1'b0;
    logic [XW-1:0]     inj_dx = '0;
    logic [YW-1:0]     inj_dy = '0;
    logic [PW-1:0]     inj_pay = '0;
    logic              inj_rdy;
    logic [3:0]        lout_vld;
    logic [3:0][FW-1:0] lout_flit;
    logic              ej_vld;
    logic [FW-1:0]     ej_flit;
    logic              starved;
    logic [2:0]        defl_cnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    defl_router #(.XW(XW), .YW(YW), .AW(AW), .PW(PW), .MY_X(MX), .MY_Y(MY)) uut (
        .clk(clk), .rst_n(rst_n), .lin_vld(lin_vld), .lin_flit(lin_flit),
        .inj_vld(inj_vld), .inj_dx(inj_dx), .inj_dy(inj_dy), .inj_pay(inj_pay),
        .inj_rdy(inj_rdy), .lout_vld(lout_vld), .lout_flit(lout_flit),
        .ej_vld(ej_vld), .ej_flit(ej_flit), .starved(starved), .defl_cnt(defl_cnt)
    );

    // expected values
    logic [3:0]         e_lvld;
    logic [3:0][FW-1:0] e_lflit;
    logic               e_ej;
    logic [FW-1:0]      e_ejflit;
    logic               e_rdy, e_starved;
    int                 e_defl, e_fire;

    function automatic logic [FW-1:0] mk(int dx, int dy, int ag, int pay);
        return {XW'(dx), YW'(dy), AW'(ag), PW'(pay)};
    endfunction

    function automatic int age_of(logic [FW-1:0] f);
        return int'(f[PW +: AW]);
    endfunction

    // 0=N 1=E 2=S 3=W 4=local
    function automatic int dir_of(int dx, int dy);
        if (dx > MX) return 1;
        if (dx < MX) return 3;
        if (dy > MY) return 0;
        if (dy < MY) return 2;
        return 4;
    endfunction

    function automatic logic [FW-1:0] hop(logic [FW-1:0] f);
        logic [FW-1:0] r = f;
        int a = age_of(f);
        if (a < (1 << AW) - 1) a++;
        r[PW +: AW] = AW'(a);
        return r;
    endfunction

    function automatic int lowest_free(logic [3:0] used);
        for (int k = 0; k < 4; k++) if (!used[k]) return k;
        return -1;
    endfunction

    // Reference: repeatedly pick the oldest unplaced flit (first index on ties).
    task automatic model();
        logic [3:0] placed = '0;
        int best, p, k;
        e_lvld = '0; e_lflit = '0; e_ej = 1'b0; e_ejflit = '0; e_defl = 0; e_fire = 0;
        for (int s = 0; s < 4; s++) begin
            best = -1;
            for (int i = 0; i < 4; i++)
                if (lin_vld[i] && !placed[i] &&
                    (best < 0 || age_of(lin_flit[i]) > age_of(lin_flit[best])))
                    best = i;
            if (best >= 0) begin
                placed[best] = 1'b1;
                p = dir_of(int'(lin_flit[best][PW+AW+YW +: XW]), int'(lin_flit[best][PW+AW +: YW]));
                if (p == 4 && !e_ej) begin
                    e_ej = 1'b1; e_ejflit = lin_flit[best];
                end else if (p != 4 && !e_lvld[p]) begin
                    e_lvld[p] = 1'b1; e_lflit[p] = hop(lin_flit[best]);
                end else begin
                    e_defl++;
                    k = lowest_free(e_lvld);
                    e_lvld[k] = 1'b1; e_lflit[k] = hop(lin_flit[best]);
                end
            end
        end
        e_rdy = (e_lvld != 4'hF);
        e_starved = inj_vld && !e_rdy;
        if (inj_vld && e_rdy) begin
            e_fire = 1;
            p = dir_of(int'(inj_dx), int'(inj_dy));
            k = (p != 4 && !e_lvld[p]) ? p : lowest_free(e_lvld);
            e_lvld[k] = 1'b1;
            e_lflit[k] = hop({inj_dx, inj_dy, AW'(0), inj_pay});
        end
    endtask

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Inputs already driven (at a falling edge); check ready now, outputs one edge later.
    task automatic run(string tag);
        int n_in;
        model();
        n_in = $countones(lin_vld);
        #1;
        check(inj_rdy === e_rdy, "R6 inj_rdy", 64'(inj_rdy), 64'(e_rdy));
        @(negedge clk);
        check(lout_vld === e_lvld, {tag, " lout_vld"}, 64'(lout_vld), 64'(e_lvld));
        for (int k = 0; k < 4; k++)
            if (e_lvld[k])
                check(lout_flit[k] === e_lflit[k], {tag, " lout_flit"}, 64'(lout_flit[k]), 64'(e_lflit[k]));
        check(ej_vld === e_ej, {tag, " R4 ej_vld"}, 64'(ej_vld), 64'(e_ej));
        if (e_ej) check(ej_flit === e_ejflit, {tag, " R4 R5 ej_flit"}, 64'(ej_flit), 64'(e_ejflit));
        check(starved === e_starved, "R7 starved", 64'(starved), 64'(e_starved));
        check(int'(defl_cnt) == e_defl, "R8 defl_cnt", 64'(defl_cnt), 64'(e_defl));
        check($countones(lout_vld) + int'(ej_vld) == n_in + e_fire, "R9 conservation",
              64'($countones(lout_vld) + int'(ej_vld)), 64'(n_in + e_fire));
    endtask

    task automatic clear();
        lin_vld = '0; lin_flit = '0; inj_vld = 1'b0; inj_dx = '0; inj_dy = '0; inj_pay = '0;
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 1234;
        void'($urandom(seed));
        clear();
        repeat (3) @(negedge clk);
        // R10 reset state, with traffic present on inputs
        lin_vld = 4'hF; lin_flit[0] = mk(4, 4, 3, 1);
        @(negedge clk);
        check(lout_vld === 4'h0 && ej_vld === 1'b0, "R10 reset valids", 64'({lout_vld, ej_vld}), 64'(0));
        check(starved === 1'b0 && defl_cnt === 3'd0, "R10 reset status", 64'({starved, defl_cnt}), 64'(0));
        clear();
        rst_n = 1'b1;
        @(negedge clk);

        // R1: from W toward larger X -> E; from S with equal X, larger Y -> N
        lin_vld = 4'b1000; lin_flit[3] = mk(4, 3, 0, 8'h11); run("R1 east");
        clear(); lin_vld = 4'b0100; lin_flit[2] = mk(2, 5, 1, 8'h12); run("R1 north");
        clear(); lin_vld = 4'b0010; lin_flit[1] = mk(0, 0, 1, 8'h13); run("R1 west");
        clear(); lin_vld = 4'b0001; lin_flit[0] = mk(2, 0, 1, 8'h14); run("R1 south");
        // R2: older S beats younger N for E; N deflected to link N
        clear(); lin_vld = 4'b0101; lin_flit[0] = mk(4, 1, 2, 8'h21); lin_flit[2] = mk(4, 1, 5, 8'h22);
        run("R2 oldest");
        // R2: equal ages, E beats W for N
        clear(); lin_vld = 4'b1010; lin_flit[1] = mk(2, 4, 3, 8'h23); lin_flit[3] = mk(2, 4, 3, 8'h24);
        run("R2 tie");
        // R3: all four want E
        clear(); lin_vld = 4'hF;
        lin_flit[0] = mk(5, 1, 1, 1); lin_flit[1] = mk(5, 1, 4, 2);
        lin_flit[2] = mk(5, 1, 2, 3); lin_flit[3] = mk(5, 1, 6, 4);
        run("R3 all east");
        // R4: two local flits, younger N deflected
        clear(); lin_vld = 4'b0011; lin_flit[0] = mk(2, 1, 1, 8'h41); lin_flit[1] = mk(2, 1, 5, 8'h42);
        run("R4 two local");
        // R5: saturation at 7
        clear(); lin_vld = 4'b0100; lin_flit[2] = mk(0, 1, 7, 8'h51); run("R5 saturate");
        // R6: three arrivals, injection preferred port taken -> lowest free
        clear(); lin_vld = 4'b0111;
        lin_flit[0] = mk(2, 0, 1, 1); lin_flit[1] = mk(0, 1, 1, 2); lin_flit[2] = mk(4, 1, 1, 3);
        inj_vld = 1'b1; inj_dx = 3'd4; inj_dy = 3'd1; inj_pay = 8'h61;
        run("R6 inject deflected");
        // R7: full load, injection refused
        clear(); lin_vld = 4'hF;
        lin_flit[0] = mk(2, 0, 1, 1); lin_flit[1] = mk(0, 1, 1, 2);
        lin_flit[2] = mk(4, 1, 1, 3); lin_flit[3] = mk(2, 4, 1, 4);
        inj_vld = 1'b1; inj_dx = 3'd0; inj_dy = 3'd0;
        run("R7 starved");
        // R6: full load with one ejection leaves room
        lin_flit[3] = mk(2, 1, 1, 4); run("R6 inject after eject");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            clear();
            for (int i = 0; i < 4; i++) begin
                lin_vld[i] = ($urandom % 4) != 0;
                lin_flit[i] = mk($urandom % 5, $urandom % 5, $urandom % 8, $urandom % 256);
            end
            inj_vld = ($urandom % 2) != 0;
            inj_dx = XW'($urandom % 5); inj_dy = YW'($urandom % 5); inj_pay = PW'($urandom);
            run("R1 R2 R3 R5 random");
        end

        clear();
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule